// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers one-cycle event pulses from up to sixteen sources into sticky status flags. It drives an active-low interrupt request whenever a flag is set and its bit in a host-written enable register is also set. Two built-in detector types turn raw inputs into events. One detector fires when the top bit of an energy accumulator goes from 0 to 1. The other fires when a signed power value changes sign.

A host reaches the block through a plain register bus with three addresses. 0x0A holds the interrupt enable mask. 0x0B returns the flags without changing them. 0x0C returns the flags and clears them. Flag 6 records that the block has come out of reset, and it can never raise the interrupt line. Flag 15 is held at zero.

A small lifecycle machine has two states. It starts in `LC_BOOT` and moves to `LC_RUN` on the first clock after reset is released (transition *boot_done*). That transition sets flag 6. Each detector has its own machine with two states. It stays in `DET_COLD` until it has taken its first sample (transition *arm*), then stays in `DET_ARMED` until reset. No detector reports an event while it is cold, so the value an input holds at reset never counts as an edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_i` at bit 1, 2, 3, 4, 5, 7, 8, 9, 11 or 12 sets the status flag at the same bit position on the next clock edge. The flag stays 1 until it is cleared by a read at 0x0C.
- R2: `irq_n_o` is 0 exactly when some flag other than bit 6 is 1 and its enable bit is 1. Otherwise `irq_n_o` is 1, and it is also 1 during reset.
- R3: Address 0x0A reads and writes the 16-bit enable register. It reads 0x0000 after reset.
- R4: Flag 6 is 0 during reset and becomes 1 on the first clock edge after reset is released. Setting enable bit 6 never drives `irq_n_o` low.
- R5: Flag 0 sets when `act_msb_i` goes from 0 to 1 between two clock edges, and flag 10 does the same for `app_msb_i`. A level held at 1 sets no flag again.
- R6: Flag 13 sets when `pwr_i` goes from negative to non-negative. Flag 14 sets when `pwr_i` goes from non-negative to negative. A value of zero counts as non-negative.
- R7: Flag 15 always reads 0. Pulses on `evt_i` bits 0, 6, 10, 13, 14 and 15 have no effect.
- R8: A read at 0x0B returns the flags on `bus_rdata_o` and leaves them unchanged.
- R9: A read at 0x0C returns the flags and clears all of them on the same edge. An event that sets a flag in that same cycle leaves that flag at 1.
- R10: Writes to 0x0B and 0x0C change no flag.
- R11: A read at any address other than 0x0A, 0x0B or 0x0C returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | One-cycle event pulses, one per flag position |
| act_msb_i | input | 1 | Top bit of the active-energy accumulator |
| app_msb_i | input | 1 | Top bit of the apparent-energy accumulator |
| pwr_i | input | PWR_W | Signed power value |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid while `bus_rd_i` is 1 |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with `PWR_W` = 8 and `ADDR_W` = 8. The narrow power width lets it drive the most negative value, -128, and the zero boundary directly, so it can check the sign detector at both ends of its range. The 8-bit address space contains an unmapped address, which lets the bench check that reads outside the three registers return zero.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned NFLAG = 16;

    localparam int BIT_ACT_HALF  = 0;
    localparam int BIT_BOOTED    = 6;
    localparam int BIT_APP_HALF  = 10;
    localparam int BIT_PWR_UP    = 13;
    localparam int BIT_PWR_DOWN  = 14;
    localparam int BIT_SPARE     = 15;

    // Flags set straight from evt_i: 1,2,3,4,5,7,8,9,11,12
    localparam logic [NFLAG-1:0] DIRECT_MASK = 16'h1BBE;

    // Flags allowed to reach the interrupt line (not 6, not 15)
    localparam logic [NFLAG-1:0] IRQ_MASK = 16'h7FBF;

    typedef enum logic {
        LC_BOOT,
        LC_RUN
    } lc_state_e;

    typedef enum logic {
        DET_COLD,
        DET_ARMED
    } det_state_e;

endpackage

// File: rtl/irq_msb_rise.sv
module irq_msb_rise
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msb_i,
    output logic rise_o
);

    det_state_e state_q, state_d;
    logic       prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_COLD:  state_d = DET_ARMED;
            DET_ARMED: state_d = DET_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_COLD;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= msb_i;
        end
    end

    always_comb begin
        rise_o = 1'b0;
        unique case (state_q)
            DET_COLD:  rise_o = 1'b0;
            DET_ARMED: rise_o = msb_i && !prev_q;
        endcase
    end

endmodule

// File: rtl/irq_sign_change.sv
module irq_sign_change
    import irq_pkg::*;
#(
    parameter int unsigned PWR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWR_W-1:0] pwr_i,
    output logic             to_pos_o,
    output logic             to_neg_o
);

    localparam int unsigned SIGN_BIT = PWR_W - 1;

    det_state_e state_q, state_d;
    logic       was_neg_q;
    logic       is_neg;

    assign is_neg = pwr_i[SIGN_BIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_COLD:  state_d = DET_ARMED;
            DET_ARMED: state_d = DET_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= DET_COLD;
            was_neg_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            was_neg_q <= is_neg;
        end
    end

    always_comb begin
        to_pos_o = 1'b0;
        to_neg_o = 1'b0;
        unique case (state_q)
            DET_COLD: begin
                to_pos_o = 1'b0;
                to_neg_o = 1'b0;
            end
            DET_ARMED: begin
                to_pos_o = was_neg_q && !is_neg;
                to_neg_o = !was_neg_q && is_neg;
            end
        endcase
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_i,
    output logic [NFLAG-1:0] flags_o
);

    logic [NFLAG-1:0] flags_q;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        if (g == BIT_SPARE) begin : g_tied
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags_q[g] <= 1'b0;
                else        flags_q[g] <= 1'b0;
            end
        end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        flags_q[g] <= 1'b0;
                else if (set_i[g]) flags_q[g] <= 1'b1;
                else if (clr_i)    flags_q[g] <= 1'b0;
            end
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned ADR_EN   = 'h0A,
    parameter int unsigned ADR_PEEK = 'h0B,
    parameter int unsigned ADR_TAKE = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [NFLAG-1:0]  wdata_i,
    input  logic [NFLAG-1:0]  flags_i,
    output logic [NFLAG-1:0]  rdata_o,
    output logic [NFLAG-1:0]  en_o,
    output logic              clr_o
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_EN);
    localparam logic [ADDR_W-1:0] A_PEEK = ADDR_W'(ADR_PEEK);
    localparam logic [ADDR_W-1:0] A_TAKE = ADDR_W'(ADR_TAKE);

    logic [NFLAG-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         en_q <= '0;
        else if (wr_i && (addr_i == A_EN))  en_q <= wdata_i;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (addr_i == A_EN)
                rdata_o = en_q;
            else if ((addr_i == A_PEEK) || (addr_i == A_TAKE))
                rdata_o = flags_i;
        end
    end

    assign clr_o = rd_i && (addr_i == A_TAKE);
    assign en_o  = en_q;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned PWR_W  = 24,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       evt_i,
    input  logic              act_msb_i,
    input  logic              app_msb_i,
    input  logic [PWR_W-1:0]  pwr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [15:0]       bus_wdata_i,
    output logic [15:0]       bus_rdata_o,
    output logic              irq_n_o
);

    lc_state_e        lc_q, lc_d;
    logic             boot_done;
    logic             act_rise, app_rise, pwr_up, pwr_down;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] en_q;
    logic             clr_rd;

    // lifecycle state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lc_q <= LC_BOOT;
        else        lc_q <= lc_d;
    end

    // lifecycle next state and outputs
    always_comb begin
        lc_d      = lc_q;
        boot_done = 1'b0;
        unique case (lc_q)
            LC_BOOT: begin
                lc_d      = LC_RUN;
                boot_done = 1'b1;
            end
            LC_RUN: begin
                lc_d      = LC_RUN;
                boot_done = 1'b0;
            end
        endcase
    end

    irq_msb_rise u_act_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .msb_i  (act_msb_i),
        .rise_o (act_rise)
    );

    irq_msb_rise u_app_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .msb_i  (app_msb_i),
        .rise_o (app_rise)
    );

    irq_sign_change #(.PWR_W(PWR_W)) u_sign (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_i    (pwr_i),
        .to_pos_o (pwr_up),
        .to_neg_o (pwr_down)
    );

    always_comb begin
        set_vec               = evt_i & DIRECT_MASK;
        set_vec[BIT_ACT_HALF] = act_rise;
        set_vec[BIT_APP_HALF] = app_rise;
        set_vec[BIT_PWR_UP]   = pwr_up;
        set_vec[BIT_PWR_DOWN] = pwr_down;
        set_vec[BIT_BOOTED]   = boot_done;
    end

    irq_flag_bank u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_rd),
        .flags_o (flags_q)
    );

    irq_host_port #(.ADDR_W(ADDR_W)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .wdata_i (bus_wdata_i),
        .flags_i (flags_q),
        .rdata_o (bus_rdata_o),
        .en_o    (en_q),
        .clr_o   (clr_rd)
    );

    assign irq_n_o = !(|(flags_q & en_q & IRQ_MASK));

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [15:0]       bus_wdata_i,
    input logic              irq_n_o,
    input logic [15:0]       flags_q,
    input logic [15:0]       en_q,
    input logic [15:0]       set_vec,
    input logic              clr_rd
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'('h0A);
    localparam logic [ADDR_W-1:0] A_PEEK = ADDR_W'('h0B);
    localparam logic [ADDR_W-1:0] A_TAKE = ADDR_W'('h0C);

    // R1: a set flag stays set unless a clearing read happened
    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_i && bus_addr_i == A_TAKE) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R4: the boot flag alone never raises the interrupt
    p_boot_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q == 16'h0040) |-> irq_n_o);

    // R7: spare flag never set
    p_spare_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_q[15]);

    // R3: enable write lands on the next edge
    p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == A_EN) |=> (en_q == $past(bus_wdata_i)));

    // R8: peek read keeps flags when no event arrives
    p_peek_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == A_PEEK && set_vec == 16'h0) |=> $stable(flags_q));

    // R9: clearing read with no event empties the flags
    p_take_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && set_vec == 16'h0) |=> (flags_q == 16'h0));

    // R10: writes to status addresses change nothing
    p_status_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_rd_i && (bus_addr_i == A_PEEK || bus_addr_i == A_TAKE)
         && set_vec == 16'h0) |=> $stable(flags_q));

endmodule

bind irq_status_ctrl irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_n_o     (irq_n_o),
    .flags_q     (flags_q),
    .en_q        (en_q),
    .set_vec     (set_vec),
    .clr_rd      (clr_rd)
);

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/100ps
module irq_status_ctrl_bench;

    localparam int PWR_W  = 8;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       evt = '0;
    logic              act_msb = 1'b0;
    logic              app_msb = 1'b0;
    logic [PWR_W-1:0]  pwr = 8'd5;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              irq_n;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irq_status_ctrl #(.PWR_W(PWR_W), .ADDR_W(ADDR_W)) u_irq_status_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .act_msb_i   (act_msb),
        .app_msb_i   (app_msb),
        .pwr_i       (pwr),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares
    always begin
        @(negedge clk);
        #2;
        if (rd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard empty", rdata, 16'h0);
            end else begin
                logic [15:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        #1;
        check(irq_n === e, tag, {15'h0, irq_n}, {15'h0, e});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog expired", 16'h0, 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        check(irq_n === 1'b1, "R2 irq idle in reset", {15'h0, irq_n}, 16'h1);
        rst_n = 1'b1;
        idle(2);

        bus_read(8'h0B, 16'h0040, "R4 boot flag after reset");
        bus_read(8'h0A, 16'h0000, "R3 enable reset value");

        bus_write(8'h0A, 16'h0040);
        check_irq(1'b1, "R4 boot flag enabled but silent");
        bus_read(8'h0C, 16'h0040, "R9 take returns boot flag");
        bus_read(8'h0B, 16'h0000, "R9 flags cleared by take");

        pulse(16'h1BBE);
        bus_read(8'h0B, 16'h1BBE, "R1 direct events latched");
        idle(3);
        bus_read(8'h0B, 16'h1BBE, "R8 peek keeps flags");

        bus_write(8'h0C, 16'hFFFF);
        bus_write(8'h0B, 16'h0000);
        bus_read(8'h0B, 16'h1BBE, "R10 status writes ignored");
        bus_read(8'h0C, 16'h1BBE, "R9 take returns flags");

        pulse(16'hE441);
        bus_read(8'h0B, 16'h0000, "R7 ignored event bits and spare");

        bus_write(8'h0A, 16'h0008);
        check_irq(1'b1, "R2 irq idle before event");
        pulse(16'h0008);
        check_irq(1'b0, "R2 irq on enabled flag");
        pulse(16'h0010);
        bus_read(8'h0C, 16'h0018, "R1 two flags before take");
        check_irq(1'b1, "R2 irq released after take");

        @(negedge clk); act_msb = 1'b1;
        idle(1);
        bus_read(8'h0B, 16'h0001, "R5 active msb rise");
        bus_read(8'h0C, 16'h0001, "R5 take active flag");
        idle(4);
        bus_read(8'h0B, 16'h0000, "R5 held msb no re-set");
        @(negedge clk); app_msb = 1'b1;
        idle(1);
        bus_read(8'h0C, 16'h0400, "R5 apparent msb rise");

        @(negedge clk); pwr = 8'h80;
        idle(1);
        bus_read(8'h0C, 16'h4000, "R6 positive to negative");
        @(negedge clk); pwr = 8'h00;
        idle(1);
        bus_read(8'h0C, 16'h2000, "R6 negative to zero");
        @(negedge clk); pwr = 8'h07;
        idle(1);
        bus_read(8'h0B, 16'h0000, "R6 stays non-negative");

        @(negedge clk);
        exp_q.push_back(16'h0000);
        tag_q.push_back("R9 take during event returns old");
        rd = 1'b1; addr = 8'h0C; evt = 16'h0020;
        @(negedge clk);
        rd = 1'b0; evt = '0;
        bus_read(8'h0B, 16'h0020, "R9 concurrent event kept");

        bus_read(8'h33, 16'h0000, "R11 unmapped read");
        bus_write(8'h0A, 16'hFFFF);
        bus_read(8'h0A, 16'hFFFF, "R3 enable readback");
        check_irq(1'b0, "R2 irq with all enabled");

        idle(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule